// File: doc/BRIEF.md
# System Control Interrupt Status Unit

This block gathers seven system-control event sources into one interrupt line: PLL lock, PLL fault, current limit, internal oscillator fault, main oscillator fault, regulator unregulated, and brown-out. Each source enters as a synchronous pulse one clock wide. Detecting the event itself is done elsewhere. Every pulse sets a sticky raw flag. A mask register selects which raw flags can reach the interrupt output. The interrupt output is raised whenever any bit of the masked view is set.

Software reaches the block through a simple register bus. The bus has an address, a write enable, write data, and combinational read data. Software reads the raw flags, the mask and the masked view. It acknowledges an event by writing 1 to the matching bit of the masked view, and that write also clears the raw flag. A routing bit controls where a brown-out goes. When the bit is clear, a brown-out is reported as an interrupt. When it is set, a brown-out produces a reset request instead.

Top module: `sysctl_irq_unit`

## Requirements
- R1: After reset, the raw flags, the mask, the routing bit, `irq_o` and `rst_req_o` are all 0, and every register reads 0.
- R2: A source pulse sets its raw flag at the next clock edge. The flag stays set until software clears it. Raw flags are read at address 0x050, bits 6:0.
- R3: The mask sits at address 0x054, bits 6:0, and can be read and written. The masked view at address 0x058 reads as raw AND mask.
- R4: `irq_o` is high exactly when at least one bit of the masked view is set.
- R5: Writing 1 to a bit at address 0x058 clears that raw flag, whatever the mask holds. Writing 0 to a bit leaves it unchanged.
- R6: If a source pulse and a clear hit the same bit in the same cycle, the flag ends up set.
- R7: Flag positions are fixed: bit 6 PLL lock, bit 5 current limit, bit 4 internal oscillator fault, bit 3 main oscillator fault, bit 2 regulator unregulated, bit 1 brown-out, bit 0 PLL fault. `src_pulse_i` uses the same positions.
- R8: The routing bit sits at address 0x05C, bit 0. When it is 1, a brown-out pulse leaves raw bit 1 unchanged. Instead, `rst_req_o` goes high for exactly the one cycle after the pulse. While the routing bit is 1, masked bit 1 reads 0.
- R9: Bits 31:7 of every register read 0, and writes to them are ignored. An unmapped address reads 0.
- R10: Writes to the raw address 0x050 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse_i | input | 7 | One-cycle event pulses, one per source |
| bus_addr_i | input | 12 | Register byte address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle brown-out reset request |

## Verification
The assertions assume that each source input is a clean synchronous level, sampled once per clock. They also assume that a write lasts one cycle with a stable address. A pulse that lasts several cycles would simply set the flag again, and the properties still hold. The bench drives every input on the falling edge and holds each pulse and each write for exactly one cycle. It samples the combinational read data and the outputs one step after the falling edge, which keeps every sample clear of the active edge.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int N_SRC = 7;

  // Flag positions; the order is visible to software.
  localparam int IDX_PLL_FAULT = 0;
  localparam int IDX_BROWNOUT  = 1;
  localparam int IDX_REG_UNREG = 2;
  localparam int IDX_MAIN_OSC  = 3;
  localparam int IDX_INT_OSC   = 4;
  localparam int IDX_CUR_LIM   = 5;
  localparam int IDX_PLL_LOCK  = 6;

  localparam logic [11:0] OFS_RAW   = 12'h050;
  localparam logic [11:0] OFS_MASK  = 12'h054;
  localparam logic [11:0] OFS_MVIEW = 12'h058;
  localparam logic [11:0] OFS_ROUTE = 12'h05C;

  typedef logic [N_SRC-1:0] flags_t;

  // Masked view: raw AND mask, with brown-out hidden while routed to reset.
  function automatic flags_t f_masked(flags_t raw, flags_t mask, logic route_rst);
    flags_t m;
    m = raw & mask;
    if (route_rst) m[IDX_BROWNOUT] = 1'b0;
    return m;
  endfunction

  // Next raw state: clear first, then set, so a set always wins.
  function automatic flags_t f_next_raw(flags_t raw, flags_t set_v, flags_t clr_v);
    return (raw & ~clr_v) | set_v;
  endfunction

  function automatic logic f_any(flags_t v);
    return |v;
  endfunction
endpackage

// File: rtl/sirq_route.sv
module sirq_route
  import sirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t src_pulse_i,
  input  logic   route_rst_i,
  output flags_t set_vec_o,
  output logic   rst_req_o
);
  logic bor_to_reset;
  logic rst_req_q;

  assign bor_to_reset = src_pulse_i[IDX_BROWNOUT] & route_rst_i;

  always_comb begin
    set_vec_o = src_pulse_i;
    if (route_rst_i) set_vec_o[IDX_BROWNOUT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= bor_to_reset;
  end

  assign rst_req_o = rst_req_q;

  // R8: a brown-out routed to reset raises the request next cycle
  assert_bor_reset_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse_i[IDX_BROWNOUT] && route_rst_i) |=> rst_req_o);
  // R8: the request is never raised without a routed brown-out the cycle before
  assert_no_spurious_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(src_pulse_i[IDX_BROWNOUT] && route_rst_i));
  // R8: a routed brown-out never reaches the flag set vector
  assert_bor_not_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    route_rst_i |-> !set_vec_o[IDX_BROWNOUT]);
endmodule

// File: rtl/sirq_status_bank.sv
module sirq_status_bank
  import sirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t set_vec_i,
  input  flags_t clr_vec_i,
  output flags_t raw_o
);
  flags_t raw_q;
  flags_t raw_d;

  assign raw_d = f_next_raw(raw_q, set_vec_i, clr_vec_i);

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) raw_q[i] <= 1'b0;
      else        raw_q[i] <= raw_d[i];
    end
  end

  assign raw_o = raw_q;

  // R6: every bit set in a cycle reads 1 afterwards, clear or not
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec_i) |=> ((raw_q & $past(set_vec_i)) == $past(set_vec_i)));
  // R2: a set flag never drops without a clear request
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw_q) & ~$past(clr_vec_i)) & ~raw_q) == '0));
  // R2: a flag never rises without a set request
  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(set_vec_i)) == '0));
  // R5: a cleared bit with no concurrent set reads 0 afterwards
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec_i) |=> ((raw_q & $past(clr_vec_i) & ~$past(set_vec_i)) == '0));
endmodule

// File: rtl/sirq_regfile.sv
module sirq_regfile
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  flags_t            raw_i,
  output flags_t            mask_o,
  output logic              route_rst_o,
  output flags_t            clr_vec_o,
  output flags_t            masked_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - N_SRC;

  flags_t mask_q;
  logic   route_q;
  logic   hit_raw, hit_mask, hit_mview, hit_route;
  logic   wr_mask, wr_route;
  logic   unused_wdata_hi;

  assign hit_raw   = (addr_i == ADDR_W'(OFS_RAW));
  assign hit_mask  = (addr_i == ADDR_W'(OFS_MASK));
  assign hit_mview = (addr_i == ADDR_W'(OFS_MVIEW));
  assign hit_route = (addr_i == ADDR_W'(OFS_ROUTE));

  assign wr_mask   = we_i & hit_mask;
  assign wr_route  = we_i & hit_route;
  assign clr_vec_o = (we_i & hit_mview) ? wdata_i[N_SRC-1:0] : '0;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:N_SRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= 1'b0;
    end else begin
      if (wr_mask)  mask_q  <= wdata_i[N_SRC-1:0];
      if (wr_route) route_q <= wdata_i[0];
    end
  end

  assign mask_o      = mask_q;
  assign route_rst_o = route_q;
  assign masked_o    = f_masked(raw_i, mask_q, route_q);

  always_comb begin
    rdata_o = '0;
    if (hit_raw)   rdata_o = {{PAD_W{1'b0}}, raw_i};
    if (hit_mask)  rdata_o = {{PAD_W{1'b0}}, mask_q};
    if (hit_mview) rdata_o = {{PAD_W{1'b0}}, masked_o};
    if (hit_route) rdata_o = {{(DATA_W-1){1'b0}}, route_q};
  end

  // R9: bits above the flag field always read 0
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[DATA_W-1:N_SRC] == '0);
  // R3: the mask changes only through a write to its own address
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
  // R8: a brown-out flag is hidden while routed to reset
  assert_bor_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    route_q |-> !masked_o[IDX_BROWNOUT]);
endmodule

// File: rtl/sysctl_irq_unit.sv
module sysctl_irq_unit
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_pulse_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  flags_t set_vec;
  flags_t clr_vec;
  flags_t raw_q;
  flags_t mask_q;
  flags_t masked;
  logic   route_rst;

  sirq_route u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_pulse_i (src_pulse_i),
    .route_rst_i (route_rst),
    .set_vec_o   (set_vec),
    .rst_req_o   (rst_req_o)
  );

  sirq_status_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec_i (set_vec),
    .clr_vec_i (clr_vec),
    .raw_o     (raw_q)
  );

  sirq_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (bus_addr_i),
    .we_i        (bus_we_i),
    .wdata_i     (bus_wdata_i),
    .raw_i       (raw_q),
    .mask_o      (mask_q),
    .route_rst_o (route_rst),
    .clr_vec_o   (clr_vec),
    .masked_o    (masked),
    .rdata_o     (bus_rdata_o)
  );

  assign irq_o = f_any(masked);

  // R4: an interrupt always has an unmasked raw flag behind it
  assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((raw_q & mask_q) != '0));
  // R4: an unmasked non-brown-out flag always raises the interrupt
  assert_irq_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((raw_q & mask_q) & ~(N_SRC'(1) << IDX_BROWNOUT)) != '0) |-> irq_o);
  // R1: nothing is pending in the first cycle after reset
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (raw_q == '0 && !irq_o && !rst_req_o));
endmodule

// File: tb/sysctl_irq_unit_tb.sv
module sysctl_irq_unit_tb;
  localparam logic [11:0] A_RAW = 12'h050, A_MASK = 12'h054,
                          A_MV = 12'h058, A_ROUTE = 12'h05C, A_NONE = 12'h0A0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  src = '0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sysctl_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .src_pulse_i(src), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [6:0] p);
    @(negedge clk); src = p;
    @(negedge clk); src = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
    rd(A_RAW, d);   chk("R1 raw", d, 32'd0);
    rd(A_MASK, d);  chk("R1 mask", d, 32'd0);
    rd(A_ROUTE, d); chk("R1 route", d, 32'd0);
  endtask

  task automatic t_sticky_order();
    logic [31:0] d;
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1) << i);
      repeat (3) @(negedge clk);
      rd(A_RAW, d); chk("R2 R7 sticky bit position", d, 32'(1) << i);
      chk("R4 masked off no irq", {31'd0, irq}, 32'd0);
      wr(A_MV, 32'(1) << i);
    end
    rd(A_RAW, d); chk("R5 all cleared", d, 32'd0);
  endtask

  task automatic t_mask_view();
    logic [31:0] d;
    pulse(7'b1011001);
    wr(A_MASK, 32'hFFFF_FF28);
    rd(A_MASK, d); chk("R3 R9 mask readback", d, 32'h28);
    rd(A_MV, d);   chk("R3 masked view", d, 32'h08);
    #1 chk("R4 irq high", {31'd0, irq}, 32'd1);
    wr(A_MASK, 32'h24);
    rd(A_MV, d);   chk("R3 masked view disjoint", d, 32'h00);
    chk("R4 irq low", {31'd0, irq}, 32'd0);
    wr(A_MASK, 32'h7F);
    rd(A_MV, d);   chk("R3 full mask", d, 32'h59);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_MV, 32'h0);
    rd(A_RAW, d); chk("R5 write zero keeps", d, 32'h59);
    wr(A_MASK, 32'h01);
    wr(A_MV, 32'h40);
    rd(A_RAW, d); chk("R5 clear while masked off", d, 32'h19);
    wr(A_MV, 32'hFFFF_FF08);
    rd(A_RAW, d); chk("R5 R9 clear bit3 only", d, 32'h11);
    chk("R4 irq from bit0", {31'd0, irq}, 32'd1);
    wr(A_MV, 32'h11);
    rd(A_RAW, d); chk("R5 cleared", d, 32'h0);
    chk("R4 irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(7'h04);
    @(negedge clk); addr = A_MV; wdata = 32'h0C; we = 1'b1; src = 7'h0C;
    @(negedge clk); we = 1'b0; wdata = '0; src = '0;
    rd(A_RAW, d); chk("R6 set wins over clear", d, 32'h0C);
    @(negedge clk); addr = A_MV; wdata = 32'h04; we = 1'b1; src = 7'h08;
    @(negedge clk); we = 1'b0; wdata = '0; src = '0;
    rd(A_RAW, d); chk("R6 other bit cleared", d, 32'h08);
    wr(A_MV, 32'h7F);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(A_MASK, 32'h7F);
    pulse(7'h02);
    rd(A_MV, d); chk("R8 brown-out as interrupt", d, 32'h02);
    chk("R8 no reset req when routed to irq", {31'd0, rst_req}, 32'd0);
    wr(A_ROUTE, 32'h1);
    rd(A_MV, d); chk("R8 hidden while routed to reset", d, 32'h00);
    chk("R8 irq hidden", {31'd0, irq}, 32'd0);
    wr(A_MV, 32'h02);
    @(negedge clk); src = 7'h02;
    @(negedge clk); src = '0; #1
    chk("R8 reset req high", {31'd0, rst_req}, 32'd1);
    @(negedge clk); #1
    chk("R8 reset req one cycle", {31'd0, rst_req}, 32'd0);
    rd(A_RAW, d); chk("R8 raw not set", d, 32'h0);
    wr(A_ROUTE, 32'h0);
    rd(A_ROUTE, d); chk("R8 route readback", d, 32'h0);
  endtask

  task automatic t_reserved_ro();
    logic [31:0] d;
    pulse(7'h20);
    wr(A_RAW, 32'hFFFF_FFFF);
    rd(A_RAW, d); chk("R10 raw write ignored", d, 32'h20);
    wr(A_RAW, 32'h0);
    rd(A_RAW, d); chk("R10 raw not cleared", d, 32'h20);
    wr(A_ROUTE, 32'hFFFF_FFFE);
    rd(A_ROUTE, d); chk("R9 route reserved ignored", d, 32'h0);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_NONE, d); chk("R9 unmapped reads 0", d, 32'h0);
    rd(A_MASK, d); chk("R9 mask untouched", d, 32'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 t_reset();
    t_sticky_order();
    t_mask_view();
    t_w1c();
    t_set_wins();
    t_route();
    t_reserved_ro();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule